// File: doc/BRIEF.md
# Decode-Stage Wrong-Path Filter and Redirector

This block sits at the decode stage of a pipeline in which both decode and execute can steer the fetch PC. Every instruction that fetch hands over carries two single-bit path tags. The execute tag is fetch's view of the execute-side epoch. The decode tag is fetch's view of the decode-side epoch. The block holds its own copy of the execute epoch and its own decode epoch. From these it works out whether the instruction belongs to the current path, and it drops instructions that do not.

An accepted instruction is passed to execute with the next PC that the direction predictor computed. When that next PC differs from the guess that fetch made, the block flips its decode epoch and sends fetch a redirect. The redirect carries the instruction's PC, the corrected target and the instruction's execute tag, so fetch can ignore it if execute has already steered elsewhere. An instruction that arrives after an execute redirect is not dropped. The block adopts both of its tags as the new epochs and then runs the usual prediction check.

At most one instruction is handled per cycle. An accepted instruction waits, with every epoch held, until the execute side is ready. A dropped instruction is consumed at once.

Top module: `dec_epoch_filter`

## Requirements
- R1: After reset, the held execute-epoch copy and the decode epoch are both 0, so an instruction tagged execute=0, decode=0 is accepted.
- R2: If the execute tag differs from the held execute-epoch copy, the instruction is accepted. When it is taken, the held copy becomes the execute tag and the decode epoch becomes the decode tag, before any toggle by R5.
- R3: If the execute tag equals the held copy and the decode tag equals the decode epoch, the instruction is accepted and the epochs are unchanged unless R5 applies.
- R4: If the execute tag equals the held copy and the decode tag differs from the decode epoch, the instruction is dropped. `in_drop` is 1, `out_valid` and `redir_valid` are 0, and neither epoch changes.
- R5: When an accepted instruction is taken and its fetch guess differs from `pred_npc`, `redir_valid` is 1 for that cycle. The redirect carries `redir_pc`=pc, `redir_npc`=`pred_npc` and `redir_ex_tag`=the execute tag, and the decode epoch becomes the inverse of the value chosen by R2 or R3.
- R6: An accepted instruction whose guess equals `pred_npc` raises no redirect.
- R7: The forwarded packet carries `out_pc`=pc, `out_npc`=`pred_npc` and `out_ex_tag`=the execute tag, and `out_valid` is 1 for every accepted instruction.
- R8: While an accepted instruction sees `out_ready`=0, `in_ready` is 0, no redirect is raised and neither epoch changes.
- R9: When R2 and R5 apply in the same cycle, the decode epoch ends as the inverse of the instruction's decode tag.
- R10: A dropped instruction is consumed (`in_ready`=1) whatever the value of `out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented |
| in_ready | output | 1 | The presented instruction is consumed this cycle |
| in_pc | input | PC_W | Instruction PC |
| in_guess | input | PC_W | Next PC guessed by fetch |
| in_ex_tag | input | 1 | Execute-epoch tag from fetch |
| in_dec_tag | input | 1 | Decode-epoch tag from fetch |
| pred_npc | input | PC_W | Next PC from the direction predictor |
| in_drop | output | 1 | The presented instruction is on a wrong path |
| out_valid | output | 1 | Forwarded packet is valid |
| out_ready | input | 1 | Execute side can take the packet |
| out_pc | output | PC_W | Forwarded PC |
| out_npc | output | PC_W | Forwarded next PC |
| out_ex_tag | output | 1 | Forwarded execute tag |
| redir_valid | output | 1 | Redirect message to fetch |
| redir_pc | output | PC_W | PC of the redirecting instruction |
| redir_npc | output | PC_W | Corrected next PC |
| redir_ex_tag | output | 1 | Execute tag of the redirecting instruction |

## Verification
The resynchronisation after an execute redirect (R2) and the decode misprediction toggle (R5) can both act on one instruction in a single cycle. The bench provokes this by presenting an instruction whose execute tag differs from the held copy and whose guess disagrees with the predictor. It checks that the redirect appears in that cycle. It then judges the resulting decode epoch from later behaviour: an instruction tagged with the inverse of the old decode tag must be accepted, and one tagged with the old decode tag must be dropped. The same cycle is also tried with `out_ready` low, to show that neither action takes effect while stalled.

// File: rtl/dec_epoch_pkg.sv
package dec_epoch_pkg;

    parameter int PC_W = 32;

    typedef logic [PC_W-1:0] pc_t;

    // Instruction as handed over by fetch
    typedef struct packed {
        pc_t  pc;
        pc_t  guess;
        logic ex_tag;
        logic dec_tag;
    } fetch_pkt_t;

    // Packet handed on to execute
    typedef struct packed {
        pc_t  pc;
        pc_t  next_pc;
        logic ex_tag;
    } fwd_pkt_t;

    // Message sent back to fetch
    typedef struct packed {
        pc_t  pc;
        pc_t  target;
        logic ex_tag;
    } redir_msg_t;

    typedef enum logic [1:0] {
        PV_ALIGNED = 2'd0,  // both tags on the current path
        PV_RESYNC  = 2'd1,  // execute has redirected; adopt the tags
        PV_STALE   = 2'd2   // wrong path; discard
    } path_verdict_t;

    function automatic path_verdict_t classify(
        input logic ex_tag, input logic dec_tag,
        input logic ex_copy, input logic dec_ep);
        if (ex_tag != ex_copy)
            return PV_RESYNC;
        else if (dec_tag == dec_ep)
            return PV_ALIGNED;
        else
            return PV_STALE;
    endfunction

endpackage

// File: rtl/dec_epoch_judge.sv
module dec_epoch_judge import dec_epoch_pkg::*; (
    input  fetch_pkt_t    pkt,
    input  logic          ex_copy,
    input  logic          dec_ep,
    output path_verdict_t verdict,
    output logic          base_dec_ep
);
    always_comb begin
        verdict = classify(pkt.ex_tag, pkt.dec_tag, ex_copy, dec_ep);
        // decode epoch to use before any misprediction toggle
        base_dec_ep = (verdict == PV_RESYNC) ? pkt.dec_tag : dec_ep;
    end
endmodule

// File: rtl/dec_epoch_regs.sv
module dec_epoch_regs (
    input  logic clk,
    input  logic rst,
    input  logic commit,
    input  logic next_ex_copy,
    input  logic next_dec_ep,
    output logic ex_copy,
    output logic dec_ep
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ex_copy <= 1'b0;
            dec_ep  <= 1'b0;
        end else if (commit) begin
            ex_copy <= next_ex_copy;
            dec_ep  <= next_dec_ep;
        end
    end
endmodule

// File: rtl/dec_redirect_gen.sv
module dec_redirect_gen import dec_epoch_pkg::*; (
    input  fetch_pkt_t pkt,
    input  pc_t        pred_npc,
    input  logic       fire,
    output logic       mispredict,
    output fwd_pkt_t   fwd,
    output logic       redir_valid,
    output redir_msg_t redir
);
    always_comb begin
        mispredict   = (pkt.guess != pred_npc);
        fwd.pc       = pkt.pc;
        fwd.next_pc  = pred_npc;
        fwd.ex_tag   = pkt.ex_tag;
        redir.pc     = pkt.pc;
        redir.target = pred_npc;
        redir.ex_tag = pkt.ex_tag;
        redir_valid  = fire && mispredict;
    end
endmodule

// File: rtl/dec_epoch_filter.sv
module dec_epoch_filter import dec_epoch_pkg::*; (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [PC_W-1:0] in_pc,
    input  logic [PC_W-1:0] in_guess,
    input  logic            in_ex_tag,
    input  logic            in_dec_tag,
    input  logic [PC_W-1:0] pred_npc,
    output logic            in_drop,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [PC_W-1:0] out_pc,
    output logic [PC_W-1:0] out_npc,
    output logic            out_ex_tag,
    output logic            redir_valid,
    output logic [PC_W-1:0] redir_pc,
    output logic [PC_W-1:0] redir_npc,
    output logic            redir_ex_tag
);
    fetch_pkt_t    pkt;
    path_verdict_t verdict;
    logic          base_dec_ep;
    logic          ex_copy, dec_ep;
    logic          accept, fire, mispredict;
    fwd_pkt_t      fwd;
    redir_msg_t    redir;

    always_comb begin
        pkt.pc      = in_pc;
        pkt.guess   = in_guess;
        pkt.ex_tag  = in_ex_tag;
        pkt.dec_tag = in_dec_tag;
    end

    dec_epoch_judge u_judge (
        .pkt(pkt), .ex_copy(ex_copy), .dec_ep(dec_ep),
        .verdict(verdict), .base_dec_ep(base_dec_ep)
    );

    always_comb begin
        accept   = in_valid && (verdict != PV_STALE);
        in_drop  = in_valid && (verdict == PV_STALE);
        fire     = accept && out_ready;
        in_ready = out_ready || in_drop;
    end

    dec_redirect_gen u_redir (
        .pkt(pkt), .pred_npc(pred_npc), .fire(fire),
        .mispredict(mispredict), .fwd(fwd),
        .redir_valid(redir_valid), .redir(redir)
    );

    dec_epoch_regs u_regs (
        .clk(clk), .rst(rst), .commit(fire),
        .next_ex_copy(in_ex_tag),
        .next_dec_ep(base_dec_ep ^ mispredict),
        .ex_copy(ex_copy), .dec_ep(dec_ep)
    );

    always_comb begin
        out_valid    = accept;
        out_pc       = fwd.pc;
        out_npc      = fwd.next_pc;
        out_ex_tag   = fwd.ex_tag;
        redir_pc     = redir.pc;
        redir_npc    = redir.target;
        redir_ex_tag = redir.ex_tag;
    end

    // ---------------- assertions ----------------
    assert_drop_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        in_drop |-> (!out_valid && !redir_valid && in_ready));

    assert_drop_hold_R4: assert property (@(posedge clk) disable iff (rst)
        in_drop |=> ($stable(ex_copy) && $stable(dec_ep)));

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !out_ready) |=> ($stable(ex_copy) && $stable(dec_ep)));

    assert_resync_copy_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && in_ex_tag != ex_copy) |=> (ex_copy == $past(in_ex_tag)));

    assert_redir_taken_R5: assert property (@(posedge clk) disable iff (rst)
        redir_valid |-> (out_valid && out_ready && out_npc != in_guess));

    assert_toggle_R5: assert property (@(posedge clk) disable iff (rst)
        (redir_valid && in_ex_tag == ex_copy) |=> (dec_ep != $past(dec_ep)));

    assert_resync_toggle_R9: assert property (@(posedge clk) disable iff (rst)
        (redir_valid && in_ex_tag != ex_copy) |=> (dec_ep == !$past(in_dec_tag)));

endmodule

// File: tb/sim_dec_epoch_filter.sv
`timescale 1ns/1ps
module sim_dec_epoch_filter;
    import dec_epoch_pkg::*;

    logic clk = 1'b0;
    logic rst;
    logic in_valid, in_ready, in_ex_tag, in_dec_tag, in_drop;
    logic [PC_W-1:0] in_pc, in_guess, pred_npc;
    logic out_valid, out_ready, out_ex_tag;
    logic [PC_W-1:0] out_pc, out_npc;
    logic redir_valid, redir_ex_tag;
    logic [PC_W-1:0] redir_pc, redir_npc;

    always #4 clk = ~clk;   // 125 MHz

    dec_epoch_filter u0 (.*);

    typedef struct {
        string           req;
        logic            rdy, drop, ov, rv, oex, rex;
        logic [PC_W-1:0] opc, onpc, rpc, rnpc;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    logic m_ex = 1'b0, m_dec = 1'b0;   // bench model of the epochs

    task automatic cmp(string req, string what, logic [PC_W-1:0] act, logic [PC_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(string req, logic v, logic ordy, logic ex, logic dc,
                         logic [PC_W-1:0] pc, logic [PC_W-1:0] g, logic [PC_W-1:0] p);
        exp_t e;
        logic acc, res, mis, fire, base;
        @(posedge clk);
        #1;
        in_valid = v; out_ready = ordy; in_ex_tag = ex; in_dec_tag = dc;
        in_pc = pc; in_guess = g; pred_npc = p;
        res  = (ex != m_ex);
        acc  = v && (res || dc == m_dec);
        mis  = (g != p);
        fire = acc && ordy;
        base = res ? dc : m_dec;
        e.req  = req;
        e.drop = v && !acc;
        e.rdy  = ordy || e.drop;
        e.ov   = acc;
        e.rv   = fire && mis;
        e.opc = pc; e.onpc = p; e.oex = ex;
        e.rpc = pc; e.rnpc = p; e.rex = ex;
        q.push_back(e);
        if (fire) begin
            m_ex  = ex;
            m_dec = base ^ mis;
        end
    endtask

    always @(negedge clk) begin
        if (!rst && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            cmp(e.req, "in_ready", in_ready, e.rdy);
            cmp(e.req, "in_drop", in_drop, e.drop);
            cmp(e.req, "out_valid", out_valid, e.ov);
            cmp(e.req, "redir_valid", redir_valid, e.rv);
            if (e.ov) begin
                cmp(e.req, "out_pc", out_pc, e.opc);
                cmp(e.req, "out_npc", out_npc, e.onpc);
                cmp(e.req, "out_ex_tag", out_ex_tag, e.oex);
            end
            if (e.rv) begin
                cmp(e.req, "redir_pc", redir_pc, e.rpc);
                cmp(e.req, "redir_npc", redir_npc, e.rnpc);
                cmp(e.req, "redir_ex_tag", redir_ex_tag, e.rex);
            end
        end
    end

    initial begin
        fork
            begin
                rst = 1'b1; in_valid = 0; out_ready = 1; in_ex_tag = 0; in_dec_tag = 0;
                in_pc = '0; in_guess = '0; pred_npc = '0;
                repeat (3) @(posedge clk);
                #1 rst = 1'b0;
                drive("R1 idle", 0, 1, 0, 0, 32'h0, 32'h0, 32'h0);
                drive("R1 R3 R7 first", 1, 1, 0, 0, 32'h100, 32'h104, 32'h104);
                drive("R5 toggle", 1, 1, 0, 0, 32'h104, 32'h108, 32'h200);
                drive("R4 R10 stale", 1, 0, 0, 0, 32'h108, 32'h10c, 32'h10c);
                drive("R3 R6 new path", 1, 1, 0, 1, 32'h200, 32'h204, 32'h204);
                drive("R2 resync", 1, 1, 1, 0, 32'h300, 32'h304, 32'h304);
                drive("R4 stale dec", 1, 1, 1, 1, 32'h304, 32'h308, 32'h400);
                drive("R8 stall", 1, 0, 1, 0, 32'h308, 32'h30c, 32'h500);
                drive("R8 stall again", 1, 0, 1, 0, 32'h308, 32'h30c, 32'h500);
                drive("R5 after stall", 1, 1, 1, 0, 32'h308, 32'h30c, 32'h500);
                drive("R4 old dec", 1, 1, 1, 0, 32'h30c, 32'h310, 32'h310);
                drive("R3 R7 dec1", 1, 1, 1, 1, 32'h500, 32'h504, 32'h504);
                drive("R8 R9 stalled both", 1, 0, 0, 1, 32'h600, 32'h604, 32'h700);
                drive("R9 resync+mis", 1, 1, 0, 1, 32'h600, 32'h604, 32'h700);
                drive("R9 inverse accepted", 1, 1, 0, 0, 32'h700, 32'h704, 32'h704);
                drive("R9 old dropped", 1, 1, 0, 1, 32'h604, 32'h608, 32'h608);
                drive("R6 idle tail", 0, 1, 0, 0, 32'h0, 32'h0, 32'h0);
                @(posedge clk);
                @(posedge clk);
            end
            begin
                repeat (2000) @(posedge clk);
                n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule